// File: doc/BRIEF.md
# Register Bus Protocol Checker

This block sits beside a simple strobe-based register bus and watches it without driving anything. The bus carries a strobe, a write-direction bit, an address, write data, read data and a ready reply from the slave. While a strobe is open, the checker compares each bus signal with its value one clock earlier. It reports every kind of misbehaviour as its own bit of an error code. It also detects strobes that wait too long for ready.

On the first violating clock, the checker latches the code bits of that clock together with the address presented on the first clock of that strobe, and raises a sticky error flag. Every violating clock adds one to a saturating error counter. A separate timeout path has its own sticky flag and its own saturating counter. Two timers count whole seconds, driven by an external one-second tick. Each timer returns to zero when its event occurs, so software can read how long ago the last error or the last timeout happened. Software reads the outputs directly and clears each path with a one-clock pulse.

Top module: `rbus_monitor`

## Requirements
- R1: Code bit 0 is set when the write bit differs from its previous-clock value while the strobe is high on both clocks and no ready has yet been seen in that strobe.
- R2: Code bit 1 is set under the same conditions as R1 when the address changes.
- R3: Code bit 2 is set under the same conditions as R1 when the write data changes.
- R4: Code bit 3 is set when the read data changes while both the strobe and ready are high on this clock and on the previous clock.
- R5: Code bit 4 is set when ready falls while the strobe is high on this clock and on the previous clock.
- R6: Code bit 5 is set when the strobe falls before any ready has been seen in that strobe (an aborted cycle).
- R7: The first violating clock loads the error code (all of its bits, possibly several) and the address from the first clock of its strobe, and sets the error flag. Code, address and flag then hold through later violations.
- R8: A clear-error pulse zeroes the flag, the code, the address and the error counter. A violation on the same clock as the clear is captured anyway, and the counter then reads 1.
- R9: The error counter adds one for each violating clock and stops at all ones.
- R10: A timeout fires on the TMO_CYCLES-th consecutive clock on which the strobe is high with no ready yet seen. It fires at most once per strobe, sets a sticky timeout flag and adds one to a saturating timeout counter. A clear-timeout pulse zeroes both.
- R11: Each seconds timer is zeroed by its own event. Otherwise it adds one on each tick and stops at all ones. An event on the same clock as a tick wins.
- R12: After reset, every output is zero.
- R13: A cycle that completes properly flags nothing. Once ready has been seen, changes to the write bit, address or write data while the strobe stays high are not errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-clock pulse once per second |
| bus_stb | input | 1 | Observed bus strobe |
| bus_we | input | 1 | Observed write direction |
| bus_addr | input | AW | Observed address |
| bus_wdata | input | DW | Observed write data |
| bus_rdata | input | DW | Observed read data |
| bus_rdy | input | 1 | Observed slave ready |
| clr_err | input | 1 | Clears the error flag, code, address and counter |
| clr_tmo | input | 1 | Clears the timeout flag and counter |
| err_flag | output | 1 | Sticky protocol-error flag |
| err_code | output | 6 | Code bits of the first violating clock |
| err_addr | output | AW | Address of the first violating cycle |
| err_count | output | CNT_W | Saturating count of violating clocks |
| err_secs | output | TMR_W | Seconds since the last violation |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_count | output | CNT_W | Saturating timeout count |
| tmo_secs | output | TMR_W | Seconds since the last timeout |

## Verification
A faulty stability check or a faulty completion tracker shows on err_code and err_count on the clock edge right after the offending bus clock, because all results are registered exactly once. A lost completion state makes a legal completed cycle report an abort. A broken capture gate makes a second violation overwrite err_code and err_addr one edge later. A wrong wait counter shifts the rise of tmo_flag away from exactly the TMO_CYCLES-th waiting edge. A timer fault appears as a missing zero, or as a missed or extra increment, on the edge that samples the event or the tick.

// File: rtl/rbmon_pkg.sv
package rbmon_pkg;

    localparam int CODE_W = 6;

    // Bit order is fixed: bit 0 is we_chg, bit 5 is aborted.
    typedef struct packed {
        logic aborted;
        logic rdy_drop;
        logic rdata_chg;
        logic wdata_chg;
        logic addr_chg;
        logic we_chg;
    } viol_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_WAIT  = 2'd1,
        W_FIRED = 2'd2
    } wait_st_e;

    function automatic logic any_viol(input viol_t v);
        return |v;
    endfunction

endpackage

// File: rtl/rbmon_watch.sv
module rbmon_watch
    import rbmon_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rdata,
    input  logic          rdy,
    output viol_t         viol,
    output logic [AW-1:0] cyc_addr,
    output logic          waiting
);

    logic          p_stb, p_we, p_rdy, done_q;
    logic [AW-1:0] p_addr, start_addr_q;
    logic [DW-1:0] p_wdata, p_rdata;
    logic          open_win, held_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_stb        <= 1'b0;
            p_we         <= 1'b0;
            p_rdy        <= 1'b0;
            p_addr       <= '0;
            p_wdata      <= '0;
            p_rdata      <= '0;
            done_q       <= 1'b0;
            start_addr_q <= '0;
        end else begin
            p_stb   <= stb;
            p_we    <= we;
            p_rdy   <= rdy;
            p_addr  <= addr;
            p_wdata <= wdata;
            p_rdata <= rdata;
            // ready seen at some clock of the current strobe
            done_q  <= stb && (done_q || rdy);
            if (stb && !p_stb) begin
                start_addr_q <= addr;
            end
        end
    end

    assign held_stb = stb && p_stb;
    assign open_win = held_stb && !done_q;

    always_comb begin
        viol           = '0;
        viol.we_chg    = open_win && (we != p_we);
        viol.addr_chg  = open_win && (addr != p_addr);
        viol.wdata_chg = open_win && (wdata != p_wdata);
        viol.rdata_chg = held_stb && rdy && p_rdy && (rdata != p_rdata);
        viol.rdy_drop  = held_stb && p_rdy && !rdy;
        viol.aborted   = p_stb && !stb && !done_q;
    end

    assign cyc_addr = start_addr_q;
    assign waiting  = stb && !done_q && !rdy;

endmodule

// File: rtl/rbmon_timeout.sv
module rbmon_timeout
    import rbmon_pkg::*;
#(
    parameter int TMO_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic waiting,
    output logic fire
);

    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

    wait_st_e      st_q;
    logic [CW-1:0] cnt_q;

    assign fire = waiting && (st_q != W_FIRED) && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= W_IDLE;
            cnt_q <= '0;
        end else if (!waiting) begin
            st_q  <= W_IDLE;
            cnt_q <= '0;
        end else if (fire) begin
            st_q  <= W_FIRED;
        end else if (st_q != W_FIRED) begin
            st_q  <= W_WAIT;
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/rbmon_tally.sv
module rbmon_tally #(
    parameter int CNT_W = 32,
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             event_i,
    input  logic             clr,
    output logic             flag,
    output logic [CNT_W-1:0] count,
    output logic [TMR_W-1:0] secs
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [TMR_W-1:0] TMR_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            count <= '0;
            secs  <= '0;
        end else begin
            if (event_i) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end

            if (clr) begin
                count <= event_i ? CNT_W'(1) : '0;
            end else if (event_i && count != CNT_MAX) begin
                count <= count + CNT_W'(1);
            end

            if (event_i) begin
                secs <= '0;
            end else if (tick && secs != TMR_MAX) begin
                secs <= secs + TMR_W'(1);
            end
        end
    end

endmodule

// File: rtl/rbus_monitor.sv
module rbus_monitor
    import rbmon_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CNT_W      = 32,
    parameter int TMR_W      = 32,
    parameter int TMO_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1s,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_rdy,
    input  logic              clr_err,
    input  logic              clr_tmo,
    output logic              err_flag,
    output logic [CODE_W-1:0] err_code,
    output logic [AW-1:0]     err_addr,
    output logic [CNT_W-1:0]  err_count,
    output logic [TMR_W-1:0]  err_secs,
    output logic              tmo_flag,
    output logic [CNT_W-1:0]  tmo_count,
    output logic [TMR_W-1:0]  tmo_secs
);

    localparam int NUM_PATHS = 2;

    viol_t         viol;
    logic [AW-1:0] cyc_addr;
    logic          waiting, tmo_fire, viol_any;

    viol_t         code_q;
    logic [AW-1:0] addr_q;

    logic [NUM_PATHS-1:0] path_ev, path_clr, path_flag;
    logic [CNT_W-1:0]     path_cnt [NUM_PATHS];
    logic [TMR_W-1:0]     path_sec [NUM_PATHS];

    rbmon_watch #(.AW(AW), .DW(DW)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .stb      (bus_stb),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .rdy      (bus_rdy),
        .viol     (viol),
        .cyc_addr (cyc_addr),
        .waiting  (waiting)
    );

    rbmon_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .waiting (waiting),
        .fire    (tmo_fire)
    );

    assign viol_any = any_viol(viol);

    // first-violation capture, held until cleared
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            addr_q <= '0;
        end else if (viol_any && (!path_flag[0] || clr_err)) begin
            code_q <= viol;
            addr_q <= cyc_addr;
        end else if (clr_err) begin
            code_q <= '0;
            addr_q <= '0;
        end
    end

    assign path_ev  = {tmo_fire, viol_any};
    assign path_clr = {clr_tmo, clr_err};

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        rbmon_tally #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_tally (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick_1s),
            .event_i (path_ev[g]),
            .clr     (path_clr[g]),
            .flag    (path_flag[g]),
            .count   (path_cnt[g]),
            .secs    (path_sec[g])
        );
    end

    assign err_flag  = path_flag[0];
    assign err_code  = code_q;
    assign err_addr  = addr_q;
    assign err_count = path_cnt[0];
    assign err_secs  = path_sec[0];
    assign tmo_flag  = path_flag[1];
    assign tmo_count = path_cnt[1];
    assign tmo_secs  = path_sec[1];

endmodule

// File: rtl/rbus_monitor_chk.sv
module rbus_monitor_chk #(
    parameter int AW    = 32,
    parameter int CNT_W = 32,
    parameter int TMR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_1s,
    input logic             clr_err,
    input logic             clr_tmo,
    input logic             err_flag,
    input logic [5:0]       err_code,
    input logic [AW-1:0]    err_addr,
    input logic [CNT_W-1:0] err_count,
    input logic [TMR_W-1:0] err_secs,
    input logic             tmo_flag,
    input logic [CNT_W-1:0] tmo_count,
    input logic [TMR_W-1:0] tmo_secs
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r7_capture_held: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_err) |=> ($stable(err_code) && $stable(err_addr)));

    a_r7_flag_matches_code: assert property (@(posedge clk) disable iff (rst)
        err_flag == (err_code != 6'd0));

    a_r9_count_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr_err && err_count == CMAX) |=> (err_count == CMAX));

    a_r9_count_single_step: assert property (@(posedge clk) disable iff (rst)
        !clr_err |=> (err_count == $past(err_count) ||
                      err_count == $past(err_count) + CNT_W'(1)));

    a_r10_tmo_sticky: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !clr_tmo) |=> tmo_flag);

    a_r10_tmo_count_step: assert property (@(posedge clk) disable iff (rst)
        !clr_tmo |=> (tmo_count == $past(tmo_count) ||
                      tmo_count == $past(tmo_count) + CNT_W'(1)));

    a_r11_err_secs_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_1s |=> (err_secs == '0 || $stable(err_secs)));

    a_r11_tmo_secs_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_1s |=> (tmo_secs == '0 || $stable(tmo_secs)));

endmodule

bind rbus_monitor rbus_monitor_chk #(.AW(AW), .CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_1s   (tick_1s),
    .clr_err   (clr_err),
    .clr_tmo   (clr_tmo),
    .err_flag  (err_flag),
    .err_code  (err_code),
    .err_addr  (err_addr),
    .err_count (err_count),
    .err_secs  (err_secs),
    .tmo_flag  (tmo_flag),
    .tmo_count (tmo_count),
    .tmo_secs  (tmo_secs)
);

// File: tb/sim_rbus_monitor.sv
module sim_rbus_monitor;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CNT_W = 3;
    localparam int TMR_W = 4;
    localparam int TMO = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1s = 1'b0, bus_stb = 1'b0, bus_we = 1'b0, bus_rdy = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata = '0;
    logic clr_err = 1'b0, clr_tmo = 1'b0;
    logic err_flag, tmo_flag;
    logic [5:0] err_code;
    logic [AW-1:0] err_addr;
    logic [CNT_W-1:0] err_count, tmo_count;
    logic [TMR_W-1:0] err_secs, tmo_secs;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rbus_monitor #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .TMR_W(TMR_W), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .tick_1s(tick_1s),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .clr_err(clr_err), .clr_tmo(clr_tmo),
        .err_flag(err_flag), .err_code(err_code), .err_addr(err_addr),
        .err_count(err_count), .err_secs(err_secs),
        .tmo_flag(tmo_flag), .tmo_count(tmo_count), .tmo_secs(tmo_secs)
    );

    typedef struct packed {
        logic       clr;
        logic       stb;
        logic       we;
        logic [7:0] addr;
        logic [7:0] wd;
        logic [7:0] rd;
        logic       rdy;
        logic [5:0] code;
        logic [7:0] eaddr;
        logic [2:0] cnt;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 0 idle
        '{1'b0,1'b1,1'b1,8'h10,8'hAA,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 1 R13 write
        '{1'b0,1'b1,1'b1,8'h10,8'hAA,8'h00,1'b1, 6'h00,8'h00,3'd0}, // 2 R13 ready
        '{1'b0,1'b1,1'b0,8'h99,8'h00,8'h00,1'b1, 6'h00,8'h00,3'd0}, // 3 R13 changes after ready
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 4
        '{1'b0,1'b1,1'b0,8'h20,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 5 R13 read
        '{1'b0,1'b1,1'b0,8'h20,8'h00,8'h55,1'b1, 6'h00,8'h00,3'd0}, // 6
        '{1'b0,1'b1,1'b0,8'h20,8'h00,8'h55,1'b1, 6'h00,8'h00,3'd0}, // 7
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 8
        '{1'b0,1'b1,1'b1,8'h30,8'h01,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 9
        '{1'b0,1'b1,1'b1,8'h31,8'h01,8'h00,1'b0, 6'h02,8'h30,3'd1}, // 10 R2 R7
        '{1'b0,1'b1,1'b1,8'h31,8'h01,8'h00,1'b1, 6'h02,8'h30,3'd1}, // 11
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h02,8'h30,3'd1}, // 12
        '{1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 13 R8 clear
        '{1'b0,1'b1,1'b1,8'h40,8'h11,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 14
        '{1'b0,1'b1,1'b0,8'h40,8'h22,8'h00,1'b0, 6'h05,8'h40,3'd1}, // 15 R1 R3 two bits
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h05,8'h40,3'd2}, // 16 R7 held, R9 count
        '{1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 17
        '{1'b0,1'b1,1'b0,8'h50,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 18
        '{1'b0,1'b1,1'b0,8'h50,8'h00,8'h66,1'b1, 6'h00,8'h00,3'd0}, // 19
        '{1'b0,1'b1,1'b0,8'h50,8'h00,8'h67,1'b1, 6'h08,8'h50,3'd1}, // 20 R4
        '{1'b0,1'b1,1'b0,8'h50,8'h00,8'h67,1'b0, 6'h08,8'h50,3'd2}, // 21 R5 counted
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h08,8'h50,3'd2}, // 22
        '{1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 23
        '{1'b0,1'b1,1'b1,8'h60,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 24
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h20,8'h60,3'd1}, // 25 R6 abort
        '{1'b1,1'b1,1'b1,8'h70,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 26
        '{1'b1,1'b1,1'b1,8'h71,8'h00,8'h00,1'b0, 6'h02,8'h70,3'd1}, // 27 R8 event beats clear
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h02,8'h70,3'd2}, // 28
        '{1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 29
        '{1'b0,1'b1,1'b0,8'h80,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}, // 30
        '{1'b0,1'b1,1'b0,8'h80,8'h00,8'h00,1'b1, 6'h00,8'h00,3'd0}, // 31
        '{1'b0,1'b1,1'b0,8'h80,8'h00,8'h00,1'b0, 6'h10,8'h80,3'd1}, // 32 R5 alone
        '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h10,8'h80,3'd1}, // 33 no abort after ready
        '{1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0, 6'h00,8'h00,3'd0}  // 34
    };

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic w, input logic [7:0] a,
                        input logic [7:0] wd, input logic [7:0] rd, input logic r, input logic t);
        @(negedge clk);
        clr_err = c; bus_stb = s; bus_we = w; bus_addr = a;
        bus_wdata = wd; bus_rdata = rd; bus_rdy = r; tick_1s = t;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R12 reset state
        check({err_flag, err_code, err_addr, err_count, err_secs,
               tmo_flag, tmo_count, tmo_secs} == '0, "R12 reset outputs",
              longint'({err_flag, err_code, err_addr, err_count}), 0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].clr, VECS[i].stb, VECS[i].we, VECS[i].addr,
                 VECS[i].wd, VECS[i].rd, VECS[i].rdy, 1'b0);
            check(err_flag == (VECS[i].code != 0) && err_code == VECS[i].code &&
                  err_addr == VECS[i].eaddr && err_count == VECS[i].cnt,
                  $sformatf("R1..R9,R13 vector %0d {flag,code,addr,cnt}", i),
                  longint'({err_flag, err_code, err_addr, err_count}),
                  longint'({VECS[i].code != 0, VECS[i].code, VECS[i].eaddr, VECS[i].cnt}));
        end

        // R9 saturation with repeated aborts
        for (int k = 0; k < 9; k++) begin
            step(1'b0, 1'b1, 1'b0, 8'h90, 8'h00, 8'h00, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        end
        check(err_count == 3'd7, "R9 saturate", err_count, 7);
        check(err_code == 6'h20 && err_addr == 8'h90, "R6 abort code/addr",
              {err_code, err_addr}, {6'h20, 8'h90});

        // R11 error timer
        check(err_secs == 0, "R11 zero after event", err_secs, 0);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0);
        check(err_secs == 4'd3, "R11 three ticks", err_secs, 3);
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b1);
        check(err_secs == 4'd15, "R11 timer saturate", err_secs, 15);
        check(tmo_secs == 4'd15, "R11 tmo timer counts", tmo_secs, 15);
        step(1'b0, 1'b1, 1'b0, 8'hA0, 0, 0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b1);
        check(err_secs == 0, "R11 event beats tick", err_secs, 0);
        step(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0);
        check(!err_flag && err_count == 0, "R8 clear", err_count, 0);

        // R10 timeout
        for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 1'b1, 8'hB0, 8'h01, 0, 1'b0, 1'b0);
        check(!tmo_flag && tmo_count == 0, "R10 not yet at TMO-1", tmo_count, 0);
        step(1'b0, 1'b1, 1'b1, 8'hB0, 8'h01, 0, 1'b0, 1'b0);
        check(tmo_flag && tmo_count == 1, "R10 fires at TMO", tmo_count, 1);
        check(tmo_secs == 0, "R11 tmo timer zeroed", tmo_secs, 0);
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b1, 8'hB0, 8'h01, 0, 1'b0, 1'b0);
        check(tmo_count == 1, "R10 once per strobe", tmo_count, 1);
        check(!err_flag, "R13 long wait alone is no protocol error", err_flag, 0);
        step(1'b0, 1'b1, 1'b1, 8'hB0, 8'h01, 0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b0, 8'hC0, 0, 0, 1'b0, 1'b0);
        check(tmo_count == 2, "R10 second strobe", tmo_count, 2);
        step(1'b0, 1'b1, 1'b0, 8'hC0, 0, 0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b1);
        check(tmo_secs == 4'd2, "R11 tmo ticks", tmo_secs, 2);
        @(negedge clk);
        clr_tmo = 1'b1;
        @(posedge clk);
        #2;
        clr_tmo = 1'b0;
        check(!tmo_flag && tmo_count == 0, "R10 clear", tmo_count, 0);
        check(!err_flag && err_count == 0, "R13 completed cycles clean", err_count, 0);

        finish_run();
    end

endmodule